// File: doc/BRIEF.md
# Configurable Sum-of-Products Macrocell

This block is one programmable logic cell. A wider logic array supplies five product terms. The cell ORs any chosen subset of them together with a cascade input from the neighbouring cell. It passes that sum on as its own cascade output, so a chain of cells can build wide sum terms. The sum then goes through an XOR whose second operand is a constant or a product term, which gives polarity control. The result feeds a single storage element. Static configuration inputs make that element a D, T, JK or SR flip-flop, or a latch that is transparent while its clock is high. The same kind of inputs choose the element's data, clock, clock-enable, clear and preset sources.

The cell runs in one fast system clock domain. Its logical clock sources (three global clocks, or a product term) are sampled on every system clock edge. An edge-triggered mode acts on the system edge where the chosen source is first seen high. The latch mode loads on every system edge while the source is high. Clear and preset are level overrides that act on the next system edge whatever the clock or enable is doing. The output pin and the buried feedback each select the stored value or the combinatorial XOR result, independently of each other. `rst_n` is an asynchronous active-low reset that is released synchronously upstream.

Fixed product-term roles:
- pterm[0]: XOR operand
- pterm[1]: separate data term
- pterm[2]: K/R input and preset term
- pterm[3]: clock term and clock-enable term
- pterm[4]: clear term

Top module: `mc_cell`

## Requirements
- R1: `casc_out` equals the OR of `casc_in` and every `pterm[i]` whose `cfg_pt_or[i]` is 1. A product term whose mask bit is 0 has no effect on the sum.
- R2: The combinatorial result is sum XOR operand. `cfg_xor_sel` picks the operand: 0 gives constant 0, 1 gives constant 1, 2 gives `pterm[0]`, and 3 gives constant 0.
- R3: `cfg_d_sel` picks the data input of the element: 0 or 3 gives the combinatorial result, 1 gives `pterm[1]`, and 2 gives `pin_in`.
- R4: `cfg_clk_sel` values 0 to 2 pick `gclk[0..2]` and value 3 picks `pterm[3]`. An edge-triggered mode updates only on the system edge where the chosen source is first sampled high after being low. It holds while the source stays high, and it ignores the sources that are not selected.
- R5: `cfg_mode` 0 is D. Mode 1 is T, which toggles when the data input is 1. Mode 2 is JK, with J as the data input and K as `pterm[2]`: 10 sets, 01 clears, 11 toggles and 00 holds. Mode 3 is SR, with S as the data input and R as `pterm[2]`: 10 sets, 01 clears, and 11 or 00 holds.
- R6: `cfg_mode` 4 is a latch. It takes the data input on every system edge while the chosen clock source is high, and it holds while that source is low. Codes 5 to 7 hold.
- R7: With a global clock and `cfg_ce_en`=1, a clock edge is ignored while `pterm[3]` is 0 and is taken while `pterm[3]` is 1.
- R8: `cfg_ar_sel` picks the clear source: 0 is off, 1 is `gclr`, 2 is `pterm[4]`, and 3 is their OR. With `cfg_ap_en`=1, `pterm[2]` presets the element. Either one acts on the next system edge without any clock.
- R9: When clear and preset are both active, the element reads 0.
- R10: `mc_out` shows the stored value when `cfg_out_reg`=1, and the combinatorial result otherwise.
- R11: `fb_out` shows the stored value when `cfg_fb_reg`=1, and the combinatorial result otherwise, independently of `cfg_out_reg`.
- R12: While `rst_n` is low, the stored value is 0.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | System clock |
| rst_n | input | 1 | Asynchronous active-low reset |
| pterm | input | 5 | Product terms from the logic array |
| casc_in | input | 1 | Cascade sum from the neighbouring cell |
| pin_in | input | 1 | Pin input used as a data source |
| gclk | input | 3 | Global clock sources (sampled) |
| gclr | input | 1 | Global clear |
| cfg_pt_or | input | 5 | Mask of product terms ORed into the sum |
| cfg_xor_sel | input | 2 | XOR operand select |
| cfg_d_sel | input | 2 | Data source select |
| cfg_mode | input | 3 | Storage mode |
| cfg_clk_sel | input | 2 | Clock source select |
| cfg_ce_en | input | 1 | Enable the product-term clock enable |
| cfg_ar_sel | input | 2 | Clear source select |
| cfg_ap_en | input | 1 | Enable the product-term preset |
| cfg_out_reg | input | 1 | Output shows the stored value |
| cfg_fb_reg | input | 1 | Feedback shows the stored value |
| casc_out | output | 1 | Sum term to the next cell |
| mc_out | output | 1 | Cell output |
| fb_out | output | 1 | Buried feedback |

## Verification
The bench checks that a clock source held high produces exactly one update. A cell that acted on the level instead would keep loading new data. JK with both inputs high must toggle, while SR with both inputs high must hold. Swapping the two would leave the value stuck in one case and flip it in the other. A clear that arrives together with a preset must win, or the element would read 1. The clock enable must block edges, and a mask bit that is off must keep its product term out of the sum. The output and feedback selects are driven to opposite settings, so that a design which ties them together shows the same value on both.

// File: rtl/mc_pkg.sv
package mc_pkg;
  typedef enum logic [2:0] {
    MODE_D     = 3'd0,
    MODE_T     = 3'd1,
    MODE_JK    = 3'd2,
    MODE_SR    = 3'd3,
    MODE_LATCH = 3'd4
  } store_mode_e;

  typedef enum logic [1:0] {
    XOP_ZERO = 2'd0,
    XOP_ONE  = 2'd1,
    XOP_PT   = 2'd2,
    XOP_RSV  = 2'd3
  } xor_op_e;

  typedef enum logic [1:0] {
    DSRC_COMB = 2'd0,
    DSRC_PT   = 2'd1,
    DSRC_PIN  = 2'd2,
    DSRC_RSV  = 2'd3
  } dsrc_e;

  typedef enum logic [1:0] {
    CLR_OFF  = 2'd0,
    CLR_GLB  = 2'd1,
    CLR_PT   = 2'd2,
    CLR_BOTH = 2'd3
  } clr_src_e;
endpackage

// File: rtl/mc_sum_path.sv
module mc_sum_path #(
  parameter int NUM_PT = 5
) (
  input  logic [NUM_PT-1:0] pterm,
  input  logic [NUM_PT-1:0] cfg_pt_or,
  input  logic              casc_in,
  input  logic              pt_xop,
  input  logic [1:0]        cfg_xor_sel,
  output logic              sum,
  output logic              comb
);
  import mc_pkg::*;

  logic [NUM_PT-1:0] masked;
  logic              xop;

  for (genvar i = 0; i < NUM_PT; i++) begin : g_mask
    assign masked[i] = pterm[i] & cfg_pt_or[i];
  end

  assign sum = (|masked) | casc_in;

  always_comb begin
    case (xor_op_e'(cfg_xor_sel))
      XOP_ONE: xop = 1'b1;
      XOP_PT:  xop = pt_xop;
      default: xop = 1'b0;
    endcase
  end

  assign comb = sum ^ xop;
endmodule

// File: rtl/mc_ctrl_sel.sv
module mc_ctrl_sel #(
  parameter int NUM_GCLK = 3,
  parameter int CSW      = 2
) (
  input  logic                clk,
  input  logic                rst_n,
  input  logic [NUM_GCLK-1:0] gclk,
  input  logic                gclr,
  input  logic                pt_clk,
  input  logic                pt_clr,
  input  logic                pt_pre,
  input  logic [CSW-1:0]      cfg_clk_sel,
  input  logic                cfg_ce_en,
  input  logic [1:0]          cfg_ar_sel,
  input  logic                cfg_ap_en,
  output logic                edge_go,
  output logic                level_go,
  output logic                clr_act,
  output logic                pre_act
);
  import mc_pkg::*;

  logic [NUM_GCLK-1:0] gpick;
  logic                is_glob;
  logic                src_now;
  logic                src_prev;
  logic                src_prev_nxt;
  logic                ce;

  for (genvar i = 0; i < NUM_GCLK; i++) begin : g_gclk
    assign gpick[i] = (cfg_clk_sel == CSW'(i)) & gclk[i];
  end

  assign is_glob = (cfg_clk_sel < CSW'(NUM_GCLK));
  assign src_now = is_glob ? (|gpick) : pt_clk;
  assign ce      = (is_glob && cfg_ce_en) ? pt_clk : 1'b1;

  assign edge_go  = src_now & ~src_prev & ce;
  assign level_go = src_now & ce;

  always_comb begin
    case (clr_src_e'(cfg_ar_sel))
      CLR_GLB:  clr_act = gclr;
      CLR_PT:   clr_act = pt_clr;
      CLR_BOTH: clr_act = gclr | pt_clr;
      default:  clr_act = 1'b0;
    endcase
  end

  assign pre_act = cfg_ap_en & pt_pre;

  assign src_prev_nxt = src_now;

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) src_prev <= 1'b0;
    else        src_prev <= src_prev_nxt;
  end
endmodule

// File: rtl/mc_reg_core.sv
module mc_reg_core (
  input  logic       clk,
  input  logic       rst_n,
  input  logic [2:0] cfg_mode,
  input  logic       d_in,
  input  logic       kr_in,
  input  logic       edge_go,
  input  logic       level_go,
  input  logic       clr_act,
  input  logic       pre_act,
  output logic       q
);
  import mc_pkg::*;

  logic q_r;
  logic q_nxt;

  always_comb begin
    q_nxt = q_r;
    if (clr_act) begin
      q_nxt = 1'b0;
    end else if (pre_act) begin
      q_nxt = 1'b1;
    end else begin
      case (store_mode_e'(cfg_mode))
        MODE_D:  if (edge_go) q_nxt = d_in;
        MODE_T:  if (edge_go && d_in) q_nxt = ~q_r;
        MODE_JK: if (edge_go) begin
          case ({d_in, kr_in})
            2'b10:   q_nxt = 1'b1;
            2'b01:   q_nxt = 1'b0;
            2'b11:   q_nxt = ~q_r;
            default: q_nxt = q_r;
          endcase
        end
        MODE_SR: if (edge_go) begin
          case ({d_in, kr_in})
            2'b10:   q_nxt = 1'b1;
            2'b01:   q_nxt = 1'b0;
            default: q_nxt = q_r;
          endcase
        end
        MODE_LATCH: if (level_go) q_nxt = d_in;
        default: q_nxt = q_r;
      endcase
    end
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) q_r <= 1'b0;
    else        q_r <= q_nxt;
  end

  assign q = q_r;
endmodule

// File: rtl/mc_cell.sv
module mc_cell #(
  parameter int NUM_PT   = 5,
  parameter int NUM_GCLK = 3,
  parameter int PT_XOP   = 0,
  parameter int PT_DATA  = 1,
  parameter int PT_KR    = 2,
  parameter int PT_CLK   = 3,
  parameter int PT_CLR   = 4,
  parameter int PT_PRE   = 2,
  localparam int CSW     = $clog2(NUM_GCLK + 1)
) (
  input  logic                clk,
  input  logic                rst_n,
  input  logic [NUM_PT-1:0]   pterm,
  input  logic                casc_in,
  input  logic                pin_in,
  input  logic [NUM_GCLK-1:0] gclk,
  input  logic                gclr,
  input  logic [NUM_PT-1:0]   cfg_pt_or,
  input  logic [1:0]          cfg_xor_sel,
  input  logic [1:0]          cfg_d_sel,
  input  logic [2:0]          cfg_mode,
  input  logic [CSW-1:0]      cfg_clk_sel,
  input  logic                cfg_ce_en,
  input  logic [1:0]          cfg_ar_sel,
  input  logic                cfg_ap_en,
  input  logic                cfg_out_reg,
  input  logic                cfg_fb_reg,
  output logic                casc_out,
  output logic                mc_out,
  output logic                fb_out
);
  import mc_pkg::*;

  logic comb;
  logic d_in;
  logic kr_in;
  logic edge_go;
  logic level_go;
  logic clr_act;
  logic pre_act;
  logic q_r;

  mc_sum_path #(.NUM_PT(NUM_PT)) u_sum (
    .pterm       (pterm),
    .cfg_pt_or   (cfg_pt_or),
    .casc_in     (casc_in),
    .pt_xop      (pterm[PT_XOP]),
    .cfg_xor_sel (cfg_xor_sel),
    .sum         (casc_out),
    .comb        (comb)
  );

  always_comb begin
    case (dsrc_e'(cfg_d_sel))
      DSRC_PT:  d_in = pterm[PT_DATA];
      DSRC_PIN: d_in = pin_in;
      default:  d_in = comb;
    endcase
  end

  assign kr_in = pterm[PT_KR];

  mc_ctrl_sel #(.NUM_GCLK(NUM_GCLK), .CSW(CSW)) u_ctrl (
    .clk         (clk),
    .rst_n       (rst_n),
    .gclk        (gclk),
    .gclr        (gclr),
    .pt_clk      (pterm[PT_CLK]),
    .pt_clr      (pterm[PT_CLR]),
    .pt_pre      (pterm[PT_PRE]),
    .cfg_clk_sel (cfg_clk_sel),
    .cfg_ce_en   (cfg_ce_en),
    .cfg_ar_sel  (cfg_ar_sel),
    .cfg_ap_en   (cfg_ap_en),
    .edge_go     (edge_go),
    .level_go    (level_go),
    .clr_act     (clr_act),
    .pre_act     (pre_act)
  );

  mc_reg_core u_core (
    .clk      (clk),
    .rst_n    (rst_n),
    .cfg_mode (cfg_mode),
    .d_in     (d_in),
    .kr_in    (kr_in),
    .edge_go  (edge_go),
    .level_go (level_go),
    .clr_act  (clr_act),
    .pre_act  (pre_act),
    .q        (q_r)
  );

  assign mc_out = cfg_out_reg ? q_r : comb;
  assign fb_out = cfg_fb_reg  ? q_r : comb;
endmodule

// File: rtl/mc_cell_chk.sv
module mc_cell_chk (
  input logic       clk,
  input logic       rst_n,
  input logic       casc_in,
  input logic       casc_out,
  input logic       clr_act,
  input logic       pre_act,
  input logic       fire,
  input logic       level,
  input logic       q,
  input logic [2:0] mode,
  input logic       d,
  input logic       kr
);
  p_cascade_pass_r1: assert property (@(posedge clk) disable iff (!rst_n)
    casc_in |-> casc_out);

  p_clear_wins_r9: assert property (@(posedge clk) disable iff (!rst_n)
    clr_act |=> !q);

  p_preset_sets_r8: assert property (@(posedge clk) disable iff (!rst_n)
    (pre_act && !clr_act) |=> q);

  p_hold_no_edge_r4: assert property (@(posedge clk) disable iff (!rst_n)
    (!clr_act && !pre_act && !fire && !(mode == 3'd4 && level)) |=> $stable(q));

  p_d_capture_r5: assert property (@(posedge clk) disable iff (!rst_n)
    (mode == 3'd0 && fire && !clr_act && !pre_act) |=> (q == $past(d)));

  p_jk_toggle_r5: assert property (@(posedge clk) disable iff (!rst_n)
    (mode == 3'd2 && fire && d && kr && !clr_act && !pre_act) |=> (q != $past(q)));
endmodule

bind mc_cell mc_cell_chk u_chk (
  .clk      (clk),
  .rst_n    (rst_n),
  .casc_in  (casc_in),
  .casc_out (casc_out),
  .clr_act  (clr_act),
  .pre_act  (pre_act),
  .fire     (edge_go),
  .level    (level_go),
  .q        (q_r),
  .mode     (cfg_mode),
  .d        (d_in),
  .kr       (kr_in)
);

// File: tb/mc_cell_tb.sv
`timescale 1ns/1ps
module mc_cell_tb_top;
  logic       clk;
  logic       rst_n;
  logic [4:0] pterm;
  logic       casc_in;
  logic       pin_in;
  logic [2:0] gclk;
  logic       gclr;
  logic [4:0] cfg_pt_or;
  logic [1:0] cfg_xor_sel;
  logic [1:0] cfg_d_sel;
  logic [2:0] cfg_mode;
  logic [1:0] cfg_clk_sel;
  logic       cfg_ce_en;
  logic [1:0] cfg_ar_sel;
  logic       cfg_ap_en;
  logic       cfg_out_reg;
  logic       cfg_fb_reg;
  logic       casc_out;
  logic       mc_out;
  logic       fb_out;

  int n_chk  = 0;
  int n_fail = 0;
  bit done   = 0;

  mc_cell dut_i (
    .clk(clk), .rst_n(rst_n), .pterm(pterm), .casc_in(casc_in), .pin_in(pin_in),
    .gclk(gclk), .gclr(gclr), .cfg_pt_or(cfg_pt_or), .cfg_xor_sel(cfg_xor_sel),
    .cfg_d_sel(cfg_d_sel), .cfg_mode(cfg_mode), .cfg_clk_sel(cfg_clk_sel),
    .cfg_ce_en(cfg_ce_en), .cfg_ar_sel(cfg_ar_sel), .cfg_ap_en(cfg_ap_en),
    .cfg_out_reg(cfg_out_reg), .cfg_fb_reg(cfg_fb_reg),
    .casc_out(casc_out), .mc_out(mc_out), .fb_out(fb_out)
  );

  initial clk = 1'b0;
  always #2.5 clk = ~clk;

  task automatic chk(input string tag, input logic got, input logic exp);
    n_chk++;
    if (got !== exp) begin
      n_fail++;
      $display("FAIL %s: actual %b expected %b", tag, got, exp);
    end
  endtask

  task automatic tick();
    @(posedge clk);
    @(negedge clk);
  endtask

  task automatic pulse0();
    gclk[0] = 1'b1; tick();
    gclk[0] = 1'b0; tick();
  endtask

  task automatic cfg_default();
    pterm = '0; casc_in = 0; pin_in = 0; gclk = '0; gclr = 0;
    cfg_pt_or = '0; cfg_xor_sel = 2'd0; cfg_d_sel = 2'd0; cfg_mode = 3'd0;
    cfg_clk_sel = 2'd0; cfg_ce_en = 0; cfg_ar_sel = 2'd0; cfg_ap_en = 0;
    cfg_out_reg = 1; cfg_fb_reg = 0;
  endtask

  task automatic set_q(input logic v);
    cfg_mode = 3'd0; cfg_d_sel = 2'd2; pin_in = v;
    pulse0();
  endtask

  task automatic t_sum();
    cfg_default(); cfg_out_reg = 0;
    cfg_pt_or = 5'b00101; pterm = 5'b00100; #1;
    chk("R1 enabled term reaches sum", casc_out, 1'b1);
    chk("R10 comb output shows sum", mc_out, 1'b1);
    pterm = 5'b00010; #1;
    chk("R1 masked term ignored", casc_out, 1'b0);
    casc_in = 1; #1;
    chk("R1 cascade in ORed", casc_out, 1'b1);
    tick();
  endtask

  task automatic t_xor();
    cfg_default(); cfg_out_reg = 0; cfg_pt_or = 5'b00100;
    pterm = 5'b00100; cfg_xor_sel = 2'd1; #1;
    chk("R2 xor with one inverts", mc_out, 1'b0);
    cfg_xor_sel = 2'd2; pterm = 5'b00101; #1;
    chk("R2 xor with pt0, both high", mc_out, 1'b0);
    pterm = 5'b00001; #1;
    chk("R2 xor with pt0, sum low", mc_out, 1'b1);
    cfg_xor_sel = 2'd3; pterm = 5'b00100; #1;
    chk("R2 code 3 acts as zero", mc_out, 1'b1);
    tick();
  endtask

  task automatic t_dsrc();
    cfg_default(); set_q(1'b0);
    cfg_d_sel = 2'd1; pterm = 5'b00010; pulse0();
    chk("R3 data from pt1", mc_out, 1'b1);
    pterm = '0; cfg_d_sel = 2'd2; pin_in = 0; pulse0();
    chk("R3 data from pin", mc_out, 1'b0);
    cfg_d_sel = 2'd0; cfg_xor_sel = 2'd1; pulse0();
    chk("R3 data from comb", mc_out, 1'b1);
  endtask

  task automatic t_clksel();
    cfg_default(); set_q(1'b0);
    cfg_clk_sel = 2'd3; cfg_d_sel = 2'd2; pin_in = 1;
    pterm = 5'b01000; tick(); pterm = '0; tick();
    chk("R4 product-term clock", mc_out, 1'b1);
    pin_in = 0; pulse0();
    chk("R4 unselected gclk0 ignored", mc_out, 1'b1);
    cfg_clk_sel = 2'd2; gclk[2] = 1; tick();
    chk("R4 gclk2 edge loads", mc_out, 1'b0);
    pin_in = 1; tick(); tick(); tick();
    chk("R4 high level does not reload", mc_out, 1'b0);
    gclk[2] = 0; tick();
  endtask

  task automatic t_modes();
    cfg_default(); set_q(1'b0);
    cfg_mode = 3'd1; pin_in = 1; pulse0();
    chk("R5 T toggles to 1", mc_out, 1'b1);
    pulse0();
    chk("R5 T toggles to 0", mc_out, 1'b0);
    pin_in = 0; pulse0();
    chk("R5 T holds with T=0", mc_out, 1'b0);
    cfg_mode = 3'd2; pin_in = 1; pterm = 5'b00000; pulse0();
    chk("R5 JK set", mc_out, 1'b1);
    pterm = 5'b00100; pulse0();
    chk("R5 JK 11 toggles", mc_out, 1'b0);
    pulse0();
    chk("R5 JK 11 toggles again", mc_out, 1'b1);
    pin_in = 0; pterm = '0; pulse0();
    chk("R5 JK 00 holds", mc_out, 1'b1);
    pterm = 5'b00100; pulse0();
    chk("R5 JK clear", mc_out, 1'b0);
    cfg_mode = 3'd3; pin_in = 1; pterm = '0; pulse0();
    chk("R5 SR set", mc_out, 1'b1);
    pterm = 5'b00100; pulse0();
    chk("R5 SR 11 holds", mc_out, 1'b1);
    pin_in = 0; pulse0();
    chk("R5 SR reset", mc_out, 1'b0);
    pterm = '0;
    cfg_mode = 3'd6; pin_in = 1; pulse0();
    chk("R6 unused mode code holds", mc_out, 1'b0);
  endtask

  task automatic t_latch();
    cfg_default(); set_q(1'b0);
    cfg_mode = 3'd4; gclk[0] = 1; pin_in = 1; tick();
    chk("R6 latch transparent high", mc_out, 1'b1);
    pin_in = 0; tick();
    chk("R6 latch follows data", mc_out, 1'b0);
    gclk[0] = 0; tick(); pin_in = 1; tick(); tick();
    chk("R6 latch holds while low", mc_out, 1'b0);
  endtask

  task automatic t_ce();
    cfg_default(); set_q(1'b0);
    cfg_ce_en = 1; pin_in = 1; pterm = 5'b00000; pulse0();
    chk("R7 edge ignored with enable low", mc_out, 1'b0);
    pterm = 5'b01000; pulse0();
    chk("R7 edge taken with enable high", mc_out, 1'b1);
    pterm = '0;
  endtask

  task automatic t_clr();
    cfg_default(); set_q(1'b1);
    cfg_ar_sel = 2'd1; gclr = 1; tick();
    chk("R8 global clear", mc_out, 1'b0);
    gclr = 0; set_q(1'b1);
    cfg_ar_sel = 2'd2; pterm = 5'b10000; tick();
    chk("R8 product-term clear", mc_out, 1'b0);
    pterm = '0; set_q(1'b1);
    cfg_ar_sel = 2'd0; gclr = 1; pterm = 5'b10000; tick();
    chk("R8 clear disabled", mc_out, 1'b1);
    pterm = '0; cfg_ar_sel = 2'd3; tick();
    chk("R8 OR clear via gclr", mc_out, 1'b0);
    gclr = 0; cfg_ar_sel = 2'd0;
    pterm = 5'b00100; tick();
    chk("R8 preset disabled", mc_out, 1'b0);
    cfg_ap_en = 1; tick();
    chk("R8 product-term preset", mc_out, 1'b1);
    pterm = '0; cfg_ap_en = 0;
  endtask

  task automatic t_prio();
    cfg_default(); set_q(1'b0);
    cfg_ar_sel = 2'd1; gclr = 1; cfg_ap_en = 1; pterm = 5'b00100;
    pin_in = 1; pulse0();
    chk("R9 clear beats preset and clock", mc_out, 1'b0);
    gclr = 0; tick();
    chk("R8 preset alone after clear drops", mc_out, 1'b1);
    pterm = '0; cfg_ap_en = 0; cfg_ar_sel = 2'd0;
  endtask

  task automatic t_outsel();
    cfg_default(); set_q(1'b1); pin_in = 0;
    cfg_out_reg = 1; cfg_fb_reg = 0; #1;
    chk("R10 output registered", mc_out, 1'b1);
    chk("R11 feedback combinatorial", fb_out, 1'b0);
    cfg_out_reg = 0; cfg_fb_reg = 1; #1;
    chk("R10 output combinatorial", mc_out, 1'b0);
    chk("R11 feedback registered", fb_out, 1'b1);
    tick();
  endtask

  task automatic t_reset_mid();
    cfg_default(); set_q(1'b1);
    rst_n = 0; #1;
    chk("R12 reset clears stored value", mc_out, 1'b0);
    tick(); rst_n = 1; tick();
  endtask

  initial begin
    #1_000_000;
    if (!done) begin
      n_fail++;
      $display("FAIL watchdog: actual timeout expected completion");
      $display("== %0d vectors applied, %0d miscompares ==", n_chk, n_fail);
      $finish;
    end
  end

  initial begin
    cfg_default();
    rst_n = 0;
    repeat (3) @(negedge clk);
    chk("R12 reset state", mc_out, 1'b0);
    rst_n = 1;
    tick();
    chk("R12 after release", mc_out, 1'b0);
    t_sum();
    t_xor();
    t_dsrc();
    t_clksel();
    t_modes();
    t_latch();
    t_ce();
    t_clr();
    t_prio();
    t_outsel();
    t_reset_mid();
    done = 1;
    $display("== %0d vectors applied, %0d miscompares ==", n_chk, n_fail);
    $finish;
  end
endmodule